// File: doc/BRIEF.md
# Segmented Address Translator

This block turns a 16-bit virtual address into a 20-bit physical address through a four-entry segment table. The two top bits of the virtual address pick a segment and the other fourteen bits are an offset inside it. Each segment entry holds a physical base, a bound, a valid flag and three permission bits: one each for fetch, load and store. A request either comes back one cycle later with base plus offset, or it comes back as a fault with a cause code. On a fault the block produces no address.

The table is written through a configuration port. That port only acts while the kernel-mode input is high. A write attempted outside kernel mode changes nothing in the table and sets a sticky privilege-error flag. After reset every segment is invalid, so all requests fault until kernel software loads the table.

Top module: `seg_xlate`

## Requirements
- R1: After reset, no response is valid, `priv_err` is 0, and every segment is invalid, so every request faults with cause 1.
- R2: The segment number is `req_vaddr[15:14]` and the offset is `req_vaddr[13:0]`.
- R3: A request that passes every check returns, one clock edge after it is sampled, `rsp_valid`=1, `rsp_fault`=0, `rsp_cause`=0 and `rsp_paddr` = (base + offset) modulo 2^20.
- R4: If the offset is greater than or equal to the segment's bound (a 15-bit value, so 16384 allows every offset), the response faults with cause 2.
- R5: A request to a segment whose valid flag is 0 faults with cause 1. This check takes priority over the bound check and the permission check.
- R6: The access kind is encoded as 0 = fetch, 1 = load and 2 = store, and it needs permission bit 0, 1 or 2 respectively. Kind 3 is never allowed. A request in bounds without the needed permission faults with cause 3. The bound check takes priority over the permission check.
- R7: A configuration write with `kernel_mode`=1 replaces the whole entry selected by `cfg_sel`. A request in the same cycle as the write still sees the old entry, and requests in later cycles see the new one.
- R8: A configuration write with `kernel_mode`=0 leaves the table unchanged and sets `priv_err`. Once set, `priv_err` stays 1 until reset.
- R9: A faulting response has `rsp_paddr`=0. A cycle with no request gives `rsp_valid`=0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vaddr | input | 16 | Virtual address (segment, offset) |
| req_kind | input | 2 | Access kind: 0 fetch, 1 load, 2 store |
| kernel_mode | input | 1 | High when privileged software is running |
| cfg_we | input | 1 | Table entry write strobe |
| cfg_sel | input | 2 | Segment entry to write |
| cfg_base | input | 20 | New physical base |
| cfg_bound | input | 15 | New bound (number of legal offsets) |
| cfg_valid | input | 1 | New valid flag |
| cfg_perm | input | 3 | New permissions {store, load, fetch} |
| rsp_valid | output | 1 | Response present |
| rsp_fault | output | 1 | Request trapped |
| rsp_cause | output | 2 | 0 none, 1 invalid, 2 bounds, 3 protection |
| rsp_paddr | output | 20 | Physical address, 0 on fault |
| priv_err | output | 1 | Sticky flag for a write attempted outside kernel mode |

## Verification
Every segment is swept with all four access kinds. The offsets tried are zero, bound-1, bound, bound+1, the largest offset, and a coarse stride across the range. Bound-1 against bound separates an off-by-one in the limit compare. Running all kinds against code-style, data-style, store-only and unused segments separates the three fault causes and their priority. A segment based near the top of the physical space with a full bound exercises the wraparound of the adder. Writes that coincide with a request, and writes made outside kernel mode, show whether table updates take effect at the right cycle or not at all.

// File: rtl/seg_xlate.sv
module seg_xlate #(
  parameter int SEG_BITS = 2,
  parameter int OFF_BITS = 14,
  parameter int PA_BITS  = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic [SEG_BITS+OFF_BITS-1:0] req_vaddr,
  input  logic [1:0]          req_kind,
  input  logic                kernel_mode,
  input  logic                cfg_we,
  input  logic [SEG_BITS-1:0] cfg_sel,
  input  logic [PA_BITS-1:0]  cfg_base,
  input  logic [OFF_BITS:0]   cfg_bound,
  input  logic                cfg_valid,
  input  logic [2:0]          cfg_perm,
  output logic                rsp_valid,
  output logic                rsp_fault,
  output logic [1:0]          rsp_cause,
  output logic [PA_BITS-1:0]  rsp_paddr,
  output logic                priv_err
);
  localparam int VA_BITS = SEG_BITS + OFF_BITS;
  localparam int NSEG    = 1 << SEG_BITS;
  localparam logic [1:0] C_NONE = 2'd0, C_INVALID = 2'd1, C_BOUNDS = 2'd2, C_PROT = 2'd3;

  logic [PA_BITS-1:0]  base_q  [NSEG];
  logic [OFF_BITS:0]   bound_q [NSEG];
  logic [2:0]          perm_q  [NSEG];
  logic [NSEG-1:0]     valid_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= '0;
      priv_err <= 1'b0;
      for (int i = 0; i < NSEG; i++) begin
        base_q[i]  <= '0;
        bound_q[i] <= '0;
        perm_q[i]  <= '0;
      end
    end else if (cfg_we) begin
      if (kernel_mode) begin
        base_q[cfg_sel]  <= cfg_base;
        bound_q[cfg_sel] <= cfg_bound;
        perm_q[cfg_sel]  <= cfg_perm;
        valid_q[cfg_sel] <= cfg_valid;
      end else begin
        priv_err <= 1'b1;
      end
    end
  end

  wire [SEG_BITS-1:0] seg = req_vaddr[VA_BITS-1:OFF_BITS];
  wire [OFF_BITS-1:0] off = req_vaddr[OFF_BITS-1:0];
  wire                over = {1'b0, off} >= bound_q[seg];
  wire [PA_BITS-1:0]  sum  = base_q[seg] + PA_BITS'(off);

  logic       kind_ok;
  logic [1:0] cause_d;

  always_comb begin
    case (req_kind)
      2'd0:    kind_ok = perm_q[seg][0];
      2'd1:    kind_ok = perm_q[seg][1];
      2'd2:    kind_ok = perm_q[seg][2];
      default: kind_ok = 1'b0;
    endcase
    if (!valid_q[seg])  cause_d = C_INVALID;
    else if (over)      cause_d = C_BOUNDS;
    else if (!kind_ok)  cause_d = C_PROT;
    else                cause_d = C_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_cause <= C_NONE;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= 1'b1;
      rsp_fault <= cause_d != C_NONE;
      rsp_cause <= cause_d;
      rsp_paddr <= (cause_d == C_NONE) ? sum : '0;
    end
  end

  AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_paddr == '0); // R9
  AST_CAUSE_MATCHES_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_fault == (rsp_cause != C_NONE))); // R3
  AST_UNUSED_SEG_TRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !valid_q[seg]) |=> (rsp_fault && rsp_cause == C_INVALID)); // R5
  AST_USER_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !kernel_mode) |=> priv_err); // R8
  AST_PRIV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    priv_err |=> priv_err); // R8
  AST_USER_WRITE_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !kernel_mode) |=> $stable(valid_q)); // R8
  AST_KERNEL_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && kernel_mode) |=> valid_q[$past(cfg_sel)] == $past(cfg_valid)); // R7
endmodule

// File: tb/test_seg_xlate.sv
module test_seg_xlate;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, req_valid, kernel_mode, cfg_we, cfg_valid;
  logic [15:0] req_vaddr;
  logic [1:0]  req_kind, cfg_sel;
  logic [19:0] cfg_base;
  logic [14:0] cfg_bound;
  logic [2:0]  cfg_perm;
  logic        rsp_valid, rsp_fault, priv_err;
  logic [1:0]  rsp_cause;
  logic [19:0] rsp_paddr;

  seg_xlate i_seg_xlate (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_kind(req_kind), .kernel_mode(kernel_mode), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_base(cfg_base), .cfg_bound(cfg_bound),
    .cfg_valid(cfg_valid), .cfg_perm(cfg_perm), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_cause(rsp_cause), .rsp_paddr(rsp_paddr),
    .priv_err(priv_err)
  );

  int n_chk = 0, n_bad = 0;
  logic        m_valid [4];
  logic [19:0] m_base  [4];
  logic [14:0] m_bound [4];
  logic [2:0]  m_perm  [4];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int ecause(int s, int off, int kind);
    if (!m_valid[s]) return 1;
    if (off >= int'(m_bound[s])) return 2;
    if (kind > 2 || !m_perm[s][kind]) return 3;
    return 0;
  endfunction

  task automatic wr(int s, logic [19:0] b, logic [14:0] bd, logic v, logic [2:0] p, logic k);
    @(negedge clk);
    cfg_we = 1'b1; kernel_mode = k; cfg_sel = 2'(s);
    cfg_base = b; cfg_bound = bd; cfg_valid = v; cfg_perm = p;
    @(negedge clk);
    cfg_we = 1'b0; kernel_mode = 1'b0;
    if (k) begin m_valid[s] = v; m_base[s] = b; m_bound[s] = bd; m_perm[s] = p; end
  endtask

  task automatic check_rsp(int s, int off, int kind);
    int c = ecause(s, off, kind);
    string tag = (c == 0) ? "R2/R3" : (c == 1) ? "R5" : (c == 2) ? "R4" : "R6";
    logic [19:0] pa = (c == 0) ? 20'(m_base[s] + 20'(off)) : 20'd0;
    chk({tag, " valid"}, 32'(rsp_valid), 32'd1);
    chk({tag, " fault"}, 32'(rsp_fault), 32'(c != 0));
    chk({tag, " cause"}, 32'(rsp_cause), 32'(c));
    chk({tag, " R9 paddr"}, 32'(rsp_paddr), 32'(pa));
  endtask

  task automatic xl(int s, int off, int kind);
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = {2'(s), 14'(off)}; req_kind = 2'(kind);
    @(negedge clk);
    req_valid = 1'b0;
    check_rsp(s, off, kind);
  endtask

  task automatic sweep();
    for (int s = 0; s < 4; s++)
      for (int k = 0; k < 4; k++) begin
        int b = int'(m_bound[s]);
        int pts[6] = '{0, b - 1, b, b + 1, 16383, 8191};
        foreach (pts[i]) if (pts[i] >= 0 && pts[i] < 16384) xl(s, pts[i], k);
        for (int o = 0; o < 16384; o += 1499) xl(s, o, k);
      end
  endtask

  task automatic finish_up();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; req_kind = '0;
    kernel_mode = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_base = '0;
    cfg_bound = '0; cfg_valid = 1'b0; cfg_perm = '0;
    for (int i = 0; i < 4; i++) begin
      m_valid[i] = 0; m_base[i] = 0; m_bound[i] = 0; m_perm[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R1 priv_err", 32'(priv_err), 32'd0);
    for (int s = 0; s < 4; s++) begin
      xl(s, 0, 1);
      chk("R1 invalid after reset", 32'(rsp_cause), 32'd1);
    end
    @(negedge clk);
    chk("R9 idle no response", 32'(rsp_valid), 32'd0);

    wr(0, 20'h04000, 15'h0700, 1'b1, 3'b011, 1'b1);
    wr(1, 20'h00000, 15'h0500, 1'b1, 3'b111, 1'b1);
    wr(3, 20'h02000, 15'h1000, 1'b1, 3'b110, 1'b1);
    sweep();

    wr(2, 20'hFF000, 15'h4000, 1'b1, 3'b100, 1'b1);
    wr(0, 20'h12345, 15'h0001, 1'b1, 3'b001, 1'b1);
    sweep();

    @(negedge clk);
    cfg_we = 1'b1; kernel_mode = 1'b1; cfg_sel = 2'd1; cfg_base = 20'h30000;
    cfg_bound = 15'h0500; cfg_valid = 1'b1; cfg_perm = 3'b111;
    req_valid = 1'b1; req_vaddr = {2'd1, 14'h0010}; req_kind = 2'd1;
    @(negedge clk);
    cfg_we = 1'b0; kernel_mode = 1'b0; req_valid = 1'b0;
    chk("R7 same-cycle sees old", 32'(rsp_paddr), 32'h00010);
    m_base[1] = 20'h30000;
    xl(1, 16'h10, 1);
    chk("R7 later sees new", 32'(rsp_paddr), 32'h30010);

    chk("R8 flag clear before", 32'(priv_err), 32'd0);
    wr(0, 20'h00000, 15'h0000, 1'b0, 3'b000, 1'b0);
    chk("R8 flag set", 32'(priv_err), 32'd1);
    xl(0, 0, 0);
    chk("R8 entry unchanged", 32'(rsp_paddr), 32'h12345);
    wr(2, 20'h00000, 15'h0000, 1'b0, 3'b000, 1'b0);
    xl(2, 100, 2);
    repeat (4) @(negedge clk);
    chk("R8 flag sticky", 32'(priv_err), 32'd1);

    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) m_valid[i] = 0;
    chk("R1 flag cleared by reset", 32'(priv_err), 32'd0);
    xl(1, 0, 1);
    chk("R1 table invalid after reset", 32'(rsp_cause), 32'd1);
    finish_up();
  end
endmodule